// File: doc/BRIEF.md
# Interrupt Routing Table with Select/Window Access

The block sits between a set of interrupt input lines and the fabric that delivers interrupts to processors. Each input line has a routing entry. The entry holds a vector, a destination, a trigger mode and a mask. When an unmasked line fires, the block emits a request that carries the entry's vector, destination and line number. The request leaves on a valid/ready stream. The consumer may stall it. While the consumer stalls, the payload stays frozen. Requests that arrive during the stall are held, one per line, and then issued lowest line first.

Software reaches the registers through two byte offsets only. A write to the select register at offset 0x00 picks an internal index. The data window at offset 0x10 then reads or writes the register at that index. Index 0x00 is the unit identifier and index 0x01 is the read-only version word. The routing table starts at index 0x10. Each 64-bit entry takes two consecutive indices: the low half at the even index and the high half at the odd index. Reads are strobed, and the data appears on the cycle after the strobe.

Top module: `irq_route_table`

## Requirements
- R1: Byte offset 0x00 is the 8-bit select register and reads back its value in bits [7:0]. Byte offset 0x10 is the data window onto the selected index. Any other offset reads zero, and writes to it are ignored. `bus_rdata` updates on the clock edge that samples `bus_rd`.
- R2: Index 0x00 holds the unit identifier. Bits [31:24] can be written and read back, and all other bits read zero. The identifier resets to zero.
- R3: Index 0x01 is read-only and reads `{8'h00, NUM_LINES-1, 8'h00, 8'h11}`. With the default configuration, bits [23:16] read 23.
- R4: The low half of entry n sits at index 0x10+2n. It holds the vector in bits [7:0], the trigger mode in bit [15] (0 = edge, 1 = level) and the mask in bit [16]. The high half sits at index 0x11+2n and holds the destination in bits [31:24]. All other bits of both halves read zero.
- R5: After reset, every entry has its mask set and all its other fields at zero, the select register is zero, and `req_valid` is low.
- R6: Indices 0x02 to 0x0F, and indices from 0x10+2*NUM_LINES upward, read zero. Writes to these indices change no register.
- R7: Each rising edge on the input line of an unmasked edge-mode entry produces exactly one request. The request carries that entry's vector, its destination and the line number.
- R8: Rising edges on a masked line are dropped. Setting the mask cancels any request from that line that has not yet reached the output slot.
- R9: An unmasked level-mode entry keeps requesting for as long as its line is high. Once the line is low and the requests already accepted have drained, no further request appears.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_vector`, `req_dest` and `req_line` hold steady. A line holds at most one waiting request outside the output slot, so further edges on that line merge into it.
- R11: When several lines are waiting, the lowest-numbered line is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | 24 | Interrupt input lines, synchronous to clk |
| req_valid | output | 1 | Request present in the output slot |
| req_ready | input | 1 | Consumer accepts the request |
| req_vector | output | 8 | Vector of the issued request |
| req_dest | output | 8 | Destination of the issued request |
| req_line | output | 5 | Input line that raised the request |

## Verification
The register file is swept over every index from 0x00 to 0x43, plus 0xFF. The sweep runs at reset, after distinct fields and junk bits have been written to every entry, and after writes aimed at the read-only and unused indices. This separates the field packing from the index decode. Every line is then pulsed once with a distinct vector and destination, which shows that routing follows the line rather than a shared entry. The stall patterns give a separate result for each case:
- Three edges on one stalled line show the merging behaviour.
- Simultaneous edges on lines 4 and 9 show the priority order.
- A mask applied while a request waits shows the cancellation.
- A held level line shows the repeated requests, and the silence once the line drops.

// File: rtl/irt_pkg.sv
`timescale 1ns/1ps
package irt_pkg;

  typedef struct packed {
    logic       mask;
    logic       level;
    logic [7:0] vector;
    logic [7:0] dest;
  } route_t;

  localparam route_t ROUTE_RESET = '{mask: 1'b1, level: 1'b0, vector: 8'h00, dest: 8'h00};

  function automatic logic [31:0] pack_low(input route_t e);
    return {15'b0, e.mask, e.level, 7'b0, e.vector};
  endfunction

  function automatic logic [31:0] pack_high(input route_t e);
    return {e.dest, 24'b0};
  endfunction

endpackage

// File: rtl/irt_regfile.sv
`timescale 1ns/1ps
module irt_regfile import irt_pkg::*; #(
  parameter int         NUM_LINES  = 24,
  parameter int         SEL_W      = 8,
  parameter int         TABLE_BASE = 16,
  parameter logic [7:0] VER_CODE   = 8'h11,
  parameter logic [7:0] ID_RESET   = 8'h00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [4:0]                  bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output route_t [NUM_LINES-1:0]      routes
);
  localparam int TABLE_END = TABLE_BASE + 2 * NUM_LINES;
  localparam logic [4:0] OFF_SEL = 5'h00;
  localparam logic [4:0] OFF_WIN = 5'h10;
  localparam logic [SEL_W-1:0] IDX_ID  = '0;
  localparam logic [SEL_W-1:0] IDX_VER = SEL_W'(1);

  logic [SEL_W-1:0] sel_q;
  logic [7:0]       id_q;
  logic             sel_hit, win_hit, tbl_hit, hi_half;
  logic [SEL_W-1:0] rel;
  logic [SEL_W-2:0] slot;
  logic [31:0]      win_val;
  logic             win_wr;
  logic             unused_wbits;

  assign sel_hit = (bus_addr == OFF_SEL);
  assign win_hit = (bus_addr == OFF_WIN);
  assign win_wr  = bus_wr && win_hit;
  assign tbl_hit = (int'(sel_q) >= TABLE_BASE) && (int'(sel_q) < TABLE_END);
  assign rel     = sel_q - SEL_W'(TABLE_BASE);
  assign slot    = rel[SEL_W-1:1];
  assign hi_half = rel[0];
  assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[14:8]};

  always_ff @(posedge clk) begin
    if (!rst_n)                sel_q <= '0;
    else if (bus_wr && sel_hit) sel_q <= bus_wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          id_q <= ID_RESET;
    else if (win_wr && sel_q == IDX_ID)  id_q <= bus_wdata[31:24];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
    route_t ent_q;
    logic   hit;
    assign hit = win_wr && tbl_hit && (slot == (SEL_W-1)'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= ROUTE_RESET;
      end else if (hit) begin
        if (hi_half) begin
          ent_q.dest <= bus_wdata[31:24];
        end else begin
          ent_q.vector <= bus_wdata[7:0];
          ent_q.level  <= bus_wdata[15];
          ent_q.mask   <= bus_wdata[16];
        end
      end
    end
    assign routes[g] = ent_q;
  end

  always_comb begin
    win_val = '0;
    if (sel_q == IDX_ID) begin
      win_val = {id_q, 24'b0};
    end else if (sel_q == IDX_VER) begin
      win_val = {8'h00, 8'(NUM_LINES - 1), 8'h00, VER_CODE};
    end else if (tbl_hit) begin
      for (int n = 0; n < NUM_LINES; n++) begin
        if (slot == (SEL_W-1)'(n))
          win_val = hi_half ? pack_high(routes[n]) : pack_low(routes[n]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (bus_rd)  bus_rdata <= sel_hit ? 32'(sel_q) : (win_hit ? win_val : 32'h0);
  end

  AST_UNIMPL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !tbl_hit && sel_q != IDX_ID) |=> ($stable(routes) && $stable(id_q))); // R6

  AST_SELECT_WRITE_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !win_hit) |=> ($stable(routes) && $stable(id_q))); // R1

endmodule

// File: rtl/irt_pending.sv
`timescale 1ns/1ps
module irt_pending import irt_pkg::*; #(
  parameter int NUM_LINES = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   irq_in,
  input  route_t [NUM_LINES-1:0] routes,
  input  logic [NUM_LINES-1:0]   take,
  output logic [NUM_LINES-1:0]   pending
);
  logic [NUM_LINES-1:0] prev_q, rise, pend_q, pend_d;

  assign rise = irq_in & ~prev_q;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (routes[i].level)
        pend_d[i] = irq_in[i] && !routes[i].mask;
      else
        pend_d[i] = ((pend_q[i] && !take[i]) || rise[i]) && !routes[i].mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    AST_MASK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      routes[g].mask |=> !pend_q[g]); // R8
    AST_EDGE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (!routes[g].mask && !routes[g].level && rise[g]) |=> pend_q[g]); // R7
  end

endmodule

// File: rtl/irt_issue.sv
`timescale 1ns/1ps
module irt_issue import irt_pkg::*; #(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   pending,
  input  route_t [NUM_LINES-1:0] routes,
  output logic [NUM_LINES-1:0]   take,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [7:0]             req_vector,
  output logic [7:0]             req_dest,
  output logic [LINE_W-1:0]      req_line
);
  logic [NUM_LINES-1:0] cand;
  logic [LINE_W-1:0]    pick_idx;
  logic [7:0]           pick_vec, pick_dest;
  logic                 found, slot_free, load;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) cand[i] = pending[i] && !routes[i].mask;
  end

  always_comb begin
    found     = 1'b0;
    pick_idx  = '0;
    pick_vec  = '0;
    pick_dest = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found     = 1'b1;
        pick_idx  = LINE_W'(i);
        pick_vec  = routes[i].vector;
        pick_dest = routes[i].dest;
      end
    end
  end

  assign slot_free = !req_valid || req_ready;
  assign load      = slot_free && found;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) take[i] = load && (pick_idx == LINE_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_vector <= '0;
      req_dest   <= '0;
      req_line   <= '0;
    end else if (load) begin
      req_valid  <= 1'b1;
      req_vector <= pick_vec;
      req_dest   <= pick_dest;
      req_line   <= pick_idx;
    end else if (req_ready) begin
      req_valid  <= 1'b0;
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vector) && $stable(req_dest) && $stable(req_line))); // R10

  AST_SLOT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cand == '0) |=> !req_valid); // R10

  AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take)); // R11

endmodule

// File: rtl/irq_route_table.sv
`timescale 1ns/1ps
module irq_route_table import irt_pkg::*; #(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [4:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [7:0]           req_vector,
  output logic [7:0]           req_dest,
  output logic [LINE_W-1:0]    req_line
);
  route_t [NUM_LINES-1:0] routes;
  logic   [NUM_LINES-1:0] pending, take;

  irt_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .routes(routes)
  );

  irt_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .routes(routes),
    .take(take), .pending(pending)
  );

  irt_issue #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .pending(pending), .routes(routes), .take(take),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
    .req_dest(req_dest), .req_line(req_line)
  );

endmodule

// File: tb/irq_route_table_test.sv
`timescale 1ns/1ps
module irq_route_table_test;
  localparam int N  = 24;
  localparam int LW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic          req_valid, req_ready = 1'b0;
  logic [7:0]    req_vector, req_dest;
  logic [LW-1:0] req_line;

  irq_route_table uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
    .req_dest(req_dest), .req_line(req_line)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] m_vec [N];
  logic [7:0] m_dest[N];
  logic       m_mask[N];
  logic       m_lvl [N];
  logic [7:0] m_id;
  logic [LW-1:0] seen[16];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung actual=%0d expected<60000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] off, input logic [31:0] d);
    @(negedge clk); bus_addr = off; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] off, output logic [31:0] d);
    @(negedge clk); bus_addr = off; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic win_write(input int idx, input logic [31:0] d);
    bus_write(5'h00, 32'(idx));
    bus_write(5'h10, d);
  endtask

  task automatic win_read(input int idx, output logic [31:0] d);
    bus_write(5'h00, 32'(idx));
    bus_read(5'h10, d);
  endtask

  function automatic logic [31:0] expect_win(input int idx);
    int n;
    if (idx == 0) return {m_id, 24'b0};
    if (idx == 1) return {8'h00, 8'(N - 1), 8'h00, 8'h11};
    if (idx >= 16 && idx < 16 + 2 * N) begin
      n = (idx - 16) / 2;
      if (idx % 2 == 1) return {m_dest[n], 24'b0};
      return {15'b0, m_mask[n], m_lvl[n], 7'b0, m_vec[n]};
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input int idx, input bit at_reset);
    if (idx == 0) return "R2";
    if (idx == 1) return "R3";
    if (idx >= 16 && idx < 16 + 2 * N) return at_reset ? "R5" : "R4";
    return "R6";
  endfunction

  task automatic sweep(input bit at_reset);
    logic [31:0] d;
    for (int idx = 0; idx < 16 + 2 * N + 4; idx++) begin
      win_read(idx, d);
      check_eq(tag_of(idx, at_reset), $sformatf("index %0h readback", idx), d, expect_win(idx));
    end
    win_read(255, d);
    check_eq("R6", "index ff readback", d, 32'h0);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); irq_in[line] = 1'b1;
    @(negedge clk); irq_in[line] = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (req_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic count_reqs(input int cycles, output int cnt);
    cnt = 0;
    req_ready = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      if (req_valid) begin
        if (cnt < 16) seen[cnt] = req_line;
        cnt++;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
  endtask

  task automatic write_low(input int n);
    win_write(16 + 2 * n, {15'b0, m_mask[n], m_lvl[n], 7'b0, m_vec[n]});
  endtask

  initial begin
    logic [31:0] d;
    bit got;
    int cnt;
    int quiet;
    logic [7:0] held_vec;

    m_id = 8'h00;
    for (int n = 0; n < N; n++) begin
      m_vec[n] = 8'h00; m_dest[n] = 8'h00; m_mask[n] = 1'b1; m_lvl[n] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R5", "req_valid after reset", 32'(req_valid), 32'h0);
    bus_read(5'h00, d);
    check_eq("R5", "select after reset", d, 32'h0);
    sweep(1'b1);

    // R1: select readback, unused offsets, ignored write
    bus_write(5'h00, 32'h2A);
    bus_read(5'h00, d);  check_eq("R1", "select readback", d, 32'h2A);
    bus_read(5'h04, d);  check_eq("R1", "offset 04 read", d, 32'h0);
    bus_read(5'h1F, d);  check_eq("R1", "offset 1f read", d, 32'h0);
    bus_write(5'h08, 32'h55);
    bus_read(5'h00, d);  check_eq("R1", "offset 08 write ignored", d, 32'h2A);

    // R2/R4: program every entry with junk outside the fields
    win_write(0, 32'h5A12_3456); m_id = 8'h5A;
    for (int n = 0; n < N; n++) begin
      m_vec[n] = 8'(8'h20 + n); m_dest[n] = 8'(3 * n + 1); m_mask[n] = 1'b0;
      win_write(16 + 2 * n, 32'hFFFE_7F00 | 32'(m_vec[n]));
      win_write(17 + 2 * n, {m_dest[n], 24'hABCDEF});
    end
    // R3/R6: writes to read-only and unused indices
    win_write(1, 32'hFFFF_FFFF);
    win_write(5, 32'hFFFF_FFFF);
    win_write(16 + 2 * N, 32'hFFFF_FFFF);
    win_write(16 + 2 * N + 1, 32'hFFFF_FFFF);
    sweep(1'b0);

    // R7: one request per edge, every line
    for (int n = 0; n < N; n++) begin
      pulse(n);
      wait_valid(got);
      check_eq("R7", $sformatf("line %0d request seen", n), 32'(got), 32'h1);
      check_eq("R7", $sformatf("line %0d vector", n), 32'(req_vector), 32'(m_vec[n]));
      check_eq("R7", $sformatf("line %0d dest", n), 32'(req_dest), 32'(m_dest[n]));
      check_eq("R7", $sformatf("line %0d index", n), 32'(req_line), 32'(n));
      req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
      quiet = 0;
      for (int k = 0; k < 4; k++) begin
        if (req_valid) quiet++;
        @(negedge clk);
      end
      check_eq("R7", $sformatf("line %0d single request", n), 32'(quiet), 32'h0);
    end

    // R10: stall, hold, merge
    pulse(3);
    @(negedge clk);
    held_vec = req_vector;
    pulse(3); pulse(3);
    check_eq("R10", "valid held under stall", 32'(req_valid), 32'h1);
    check_eq("R10", "vector held under stall", 32'(req_vector), 32'(held_vec));
    check_eq("R10", "line held under stall", 32'(req_line), 32'd3);
    count_reqs(10, cnt);
    check_eq("R10", "three edges while stalled give two requests", 32'(cnt), 32'd2);

    // R11: simultaneous edges
    @(negedge clk); irq_in[9] = 1'b1; irq_in[4] = 1'b1;
    @(negedge clk); irq_in[9] = 1'b0; irq_in[4] = 1'b0;
    @(negedge clk);
    count_reqs(10, cnt);
    check_eq("R11", "two requests issued", 32'(cnt), 32'd2);
    check_eq("R11", "first issued line", 32'(seen[0]), 32'd4);
    check_eq("R11", "second issued line", 32'(seen[1]), 32'd9);

    // R8: masked line and cancellation
    m_mask[6] = 1'b1; write_low(6);
    pulse(6);
    count_reqs(8, cnt);
    check_eq("R8", "masked edge dropped", 32'(cnt), 32'h0);
    m_mask[6] = 1'b0; write_low(6);
    pulse(2);
    pulse(6);
    m_mask[6] = 1'b1; write_low(6);
    count_reqs(10, cnt);
    check_eq("R8", "only unmasked request survives", 32'(cnt), 32'd1);
    check_eq("R8", "surviving line", 32'(seen[0]), 32'd2);

    // R9: level entry
    m_lvl[10] = 1'b1; write_low(10);
    @(negedge clk); irq_in[10] = 1'b1;
    count_reqs(12, cnt);
    check_eq("R9", "level line repeats while high", 32'(cnt >= 2), 32'h1);
    check_eq("R9", "level request line", 32'(seen[1]), 32'd10);
    req_ready = 1'b1;
    irq_in[10] = 1'b0;
    repeat (4) @(negedge clk);
    count_reqs(10, cnt);
    check_eq("R9", "no request after level drops", 32'(cnt), 32'h0);

    sweep(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule